// File: doc/BRIEF.md
# Alternating Dual-DAC Successive-Approximation Sequencer

The block sequences a 9-bit successive-approximation converter that has two capacitive DACs. The DACs trade jobs every sample period. One DAC sits on the integrating node and samples. The other runs the bit search on the charge it collected in the previous period. The block drives the two complementary role switches and holds a code register for each DAC. Each bit cycle it issues a comparator strobe and applies the decision it gets back. After the last decision it presents the result with a one-cycle valid pulse.

A sample period is a fixed number of master clocks: 48 clocks of a 480 kHz oscillator give a 10 kHz conversion rate. The search takes one clock per bit, directly after the first cycle of the period, and the clocks after it are idle. A 2-bit full-scale gain select passes to the reference logic. It is taken up only at a period boundary, so the full scale never changes during a search.

Top module: `dual_sar_ctrl`

## Requirements
- R1: While rst_ni is low, sel_a_smp_o=1, sel_b_smp_o=0, both DAC codes are 0, result_o=0, valid_o=0, gain_o=0 and cmp_strobe_o=0. Period cycle 0 follows the release of reset.
- R2: Exactly one of sel_a_smp_o and sel_b_smp_o is high in every cycle.
- R3: The roles swap once every PERIOD (48) clocks, at the edge that ends cycle 47. The first conversion after reset runs on DAC B, and after that the converting DAC alternates.
- R4: cmp_strobe_o is high in period cycles 1 to 9, which is exactly NBITS cycles per period. No role swap falls inside those cycles.
- R5: The search runs MSB first. In cycle k (1..9) the converting code has bit 9-k set as the trial. A high cmp_above_i (the DAC is above the input) clears that bit on the next edge, and the next lower bit is set. With a comparator that reports code > vin, the result equals vin for any vin in 0..511.
- R6: valid_o is high for exactly one cycle, in period cycle 10, with result_o updated in that same cycle. result_o then holds until the next valid pulse.
- R7: From the second cycle after reset onward, the code of the DAC that is sampling equals mid-scale 0x100.
- R8: cmp_above_i has no effect outside strobe cycles. A converting code holds its final value during the idle cycles, and result_o stays unchanged.
- R9: gain_o takes the value of gain_sel_i only at the edge that swaps the roles. A change of gain_sel_i inside a period does not reach gain_o before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 48 per sample period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gain_sel_i | input | 2 | Requested full-scale gain setting |
| cmp_above_i | input | 1 | Comparator decision: DAC above input |
| cmp_strobe_o | output | 1 | Comparator strobe, one per bit |
| sel_a_smp_o | output | 1 | DAC A connected for sampling |
| sel_b_smp_o | output | 1 | DAC B connected for sampling |
| dac_a_code_o | output | 9 | Code register of DAC A |
| dac_b_code_o | output | 9 | Code register of DAC B |
| gain_o | output | 2 | Full-scale gain applied to the references |
| result_o | output | 9 | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
Two things happen on the same clock edge: the gain update and the role swap. Both come at the end of cycle 47. The bench changes gain_sel_i in the middle of a period and checks that gain_o does not move until the swap. It then drives a new gain value exactly in cycle 47 and checks that gain_o and the role switches change together on the next edge. During idle cycles it forces the comparator high and checks that neither the converting code nor result_o reacts. This separates a decision that is applied from one that arrives outside the strobe window.

// File: rtl/dual_sar_pkg.sv
package dual_sar_pkg;
  typedef enum logic {
    ROLE_A_SMP = 1'b0,
    ROLE_B_SMP = 1'b1
  } role_e;

  function automatic logic [31:0] mid_code(input int nbits);
    return 32'(1) << (nbits - 1);
  endfunction
endpackage

// File: rtl/sar_period_timer.sv
module sar_period_timer #(
  parameter int PERIOD = 48,
  parameter int NBITS  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             strobe_o,
  output logic             load_o,
  output logic             swap_o,
  output logic             last_o,
  output logic [NBITS-1:0] test_mask_o,
  output logic [NBITS-1:0] next_mask_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] NB_CNT   = CNT_W'(NBITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = (cnt_q != '0) && (cnt_q <= NB_CNT);
  assign last_o   = (cnt_q == NB_CNT);
  assign swap_o   = (cnt_q == LAST_CNT);
  // cycle 0 loads the trial for the MSB (covers the first period after reset)
  assign load_o   = (cnt_q == '0) || swap_o;

  // bit k is under test in cycle NBITS-k; next_mask pre-sets bit k one cycle earlier
  for (genvar k = 0; k < NBITS; k++) begin : g_mask
    assign test_mask_o[k] = strobe_o && (cnt_q == CNT_W'(NBITS - k));
    if (k < NBITS - 1) begin : g_nxt
      assign next_mask_o[k] = strobe_o && (cnt_q == CNT_W'(NBITS - 1 - k));
    end else begin : g_top
      assign next_mask_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/sar_role_ctrl.sv
module sar_role_ctrl
  import dual_sar_pkg::*;
#(
  parameter int GAIN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic [GAIN_W-1:0] gain_sel_i,
  output role_e             role_o,
  output logic              sel_a_smp_o,
  output logic              sel_b_smp_o,
  output logic [GAIN_W-1:0] gain_o
);
  role_e             role_q;
  logic [GAIN_W-1:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_q <= ROLE_A_SMP;
      gain_q <= '0;
    end else if (swap_i) begin
      role_q <= (role_q == ROLE_A_SMP) ? ROLE_B_SMP : ROLE_A_SMP;
      gain_q <= gain_sel_i;
    end
  end

  assign role_o      = role_q;
  assign sel_a_smp_o = (role_q == ROLE_A_SMP);
  assign sel_b_smp_o = (role_q == ROLE_B_SMP);
  assign gain_o      = gain_q;
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int NBITS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             conv_i,
  input  logic             strobe_i,
  input  logic             cmp_above_i,
  input  logic [NBITS-1:0] test_mask_i,
  input  logic [NBITS-1:0] next_mask_i,
  output logic [NBITS-1:0] code_o,
  output logic [NBITS-1:0] code_nxt_o
);
  localparam logic [NBITS-1:0] MID = NBITS'(dual_sar_pkg::mid_code(NBITS));

  logic [NBITS-1:0] code_q;

  always_comb begin
    code_nxt_o = code_q;
    if (load_i)
      code_nxt_o = MID;
    else if (conv_i && strobe_i)
      code_nxt_o = (code_q & ~(cmp_above_i ? test_mask_i : '0)) | next_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_nxt_o;
  end

  assign code_o = code_q;
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int NBITS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [NBITS-1:0] data_i,
  output logic [NBITS-1:0] result_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) result_o <= data_i;
    end
  end
endmodule

// File: rtl/dual_sar_ctrl.sv
module dual_sar_ctrl
  import dual_sar_pkg::*;
#(
  parameter int NBITS  = 9,
  parameter int PERIOD = 48,
  parameter int GAIN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAIN_W-1:0] gain_sel_i,
  input  logic              cmp_above_i,
  output logic              cmp_strobe_o,
  output logic              sel_a_smp_o,
  output logic              sel_b_smp_o,
  output logic [NBITS-1:0]  dac_a_code_o,
  output logic [NBITS-1:0]  dac_b_code_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [NBITS-1:0]  result_o,
  output logic              valid_o
);
  localparam int NDAC = 2;

  logic             strobe, load, swap, last;
  logic [NBITS-1:0] test_mask, next_mask;
  role_e            role;
  logic [NBITS-1:0] code    [NDAC];
  logic [NBITS-1:0] code_nxt[NDAC];
  logic [NBITS-1:0] conv_nxt;

  sar_period_timer #(.PERIOD(PERIOD), .NBITS(NBITS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_o    (strobe),
    .load_o      (load),
    .swap_o      (swap),
    .last_o      (last),
    .test_mask_o (test_mask),
    .next_mask_o (next_mask)
  );

  sar_role_ctrl #(.GAIN_W(GAIN_W)) u_role (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_i      (swap),
    .gain_sel_i  (gain_sel_i),
    .role_o      (role),
    .sel_a_smp_o (sel_a_smp_o),
    .sel_b_smp_o (sel_b_smp_o),
    .gain_o      (gain_o)
  );

  // index 0 is DAC A, index 1 is DAC B; a DAC converts while the other samples
  for (genvar d = 0; d < NDAC; d++) begin : g_dac
    localparam role_e CONV_ROLE = (d == 0) ? ROLE_B_SMP : ROLE_A_SMP;
    sar_code_reg #(.NBITS(NBITS)) u_code (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .conv_i      (role == CONV_ROLE),
      .strobe_i    (strobe),
      .cmp_above_i (cmp_above_i),
      .test_mask_i (test_mask),
      .next_mask_i (next_mask),
      .code_o      (code[d]),
      .code_nxt_o  (code_nxt[d])
    );
  end

  assign conv_nxt = (role == ROLE_A_SMP) ? code_nxt[1] : code_nxt[0];

  sar_result_reg #(.NBITS(NBITS)) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (strobe && last),
    .data_i    (conv_nxt),
    .result_o  (result_o),
    .valid_o   (valid_o)
  );

  assign cmp_strobe_o = strobe;
  assign dac_a_code_o = code[0];
  assign dac_b_code_o = code[1];
endmodule

// File: rtl/dual_sar_ctrl_chk.sv
module dual_sar_ctrl_chk #(
  parameter int NBITS  = 9,
  parameter int GAIN_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_strobe_i,
  input logic              sel_a_smp_i,
  input logic              sel_b_smp_i,
  input logic [NBITS-1:0]  dac_a_code_i,
  input logic [NBITS-1:0]  dac_b_code_i,
  input logic [GAIN_W-1:0] gain_i,
  input logic [NBITS-1:0]  result_i,
  input logic              valid_i
);
  localparam logic [NBITS-1:0] MID = NBITS'(dual_sar_pkg::mid_code(NBITS));

  logic p1_q, p2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= 1'b0;
      p2_q <= 1'b0;
    end else begin
      p1_q <= 1'b1;
      p2_q <= p1_q;
    end
  end

  // R2
  roles_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_a_smp_i != sel_b_smp_i);

  // R4
  strobe_no_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q && cmp_strobe_i) |-> $stable(sel_a_smp_i));

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q && !valid_i) |-> $stable(result_i));

  // R7
  smp_a_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q && sel_a_smp_i && $past(sel_a_smp_i)) |-> (dac_a_code_i == MID));

  // R7
  smp_b_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q && sel_b_smp_i && $past(sel_b_smp_i)) |-> (dac_b_code_i == MID));

  // R8
  conv_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_q && !sel_a_smp_i && $past(!sel_a_smp_i) && !$past(cmp_strobe_i))
      |-> $stable(dac_a_code_i));

  // R8
  conv_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_q && !sel_b_smp_i && $past(!sel_b_smp_i) && !$past(cmp_strobe_i))
      |-> $stable(dac_b_code_i));

  // R9
  gain_at_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q && !$stable(gain_i)) |-> !$stable(sel_a_smp_i));
endmodule

bind dual_sar_ctrl dual_sar_ctrl_chk #(.NBITS(NBITS), .GAIN_W(GAIN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmp_strobe_i (cmp_strobe_o),
  .sel_a_smp_i  (sel_a_smp_o),
  .sel_b_smp_i  (sel_b_smp_o),
  .dac_a_code_i (dac_a_code_o),
  .dac_b_code_i (dac_b_code_o),
  .gain_i       (gain_o),
  .result_i     (result_o),
  .valid_i      (valid_o)
);

// File: tb/dual_sar_ctrl_test.sv
module dual_sar_ctrl_test;
  localparam int NBITS = 9;
  localparam int NVEC  = 12;
  localparam logic [NBITS-1:0] MID = 9'h100;
  localparam logic [NBITS-1:0] VIN_TAB [NVEC] = '{
    9'd0, 9'd511, 9'd256, 9'd255, 9'd1, 9'd510,
    9'd170, 9'd341, 9'd128, 9'd383, 9'd2, 9'd300
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       gain_sel_i = 2'd0;
  logic             cmp_above_i;
  logic             cmp_strobe_o, sel_a_smp_o, sel_b_smp_o, valid_o;
  logic [NBITS-1:0] dac_a_code_o, dac_b_code_o, result_o;
  logic [1:0]       gain_o;

  logic [NBITS-1:0] vin = '0;
  logic             force_hi = 1'b0;
  logic [NBITS-1:0] conv_code;
  int               nchk = 0, nfail = 0, strobe_cnt = 0, strobe_prev = 0;

  always #10 clk_i = ~clk_i;

  // comparator model: DAC above input
  assign conv_code   = sel_a_smp_o ? dac_b_code_o : dac_a_code_o;
  assign cmp_above_i = force_hi ? 1'b1 : (conv_code > vin);

  always @(posedge clk_i) if (cmp_strobe_o) strobe_cnt <= strobe_cnt + 1;

  dual_sar_ctrl uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gain_sel_i   (gain_sel_i),
    .cmp_above_i  (cmp_above_i),
    .cmp_strobe_o (cmp_strobe_o),
    .sel_a_smp_o  (sel_a_smp_o),
    .sel_b_smp_o  (sel_b_smp_o),
    .dac_a_code_o (dac_a_code_o),
    .dac_b_code_o (dac_b_code_o),
    .gain_o       (gain_o),
    .result_o     (result_o),
    .valid_o      (valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the negedge of period cycle 10
  task automatic wait_valid();
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!valid_o && n < 200);
    chk(valid_o, "R6 valid timeout", int'(valid_o), 1);
  endtask

  task automatic reset_checks(input string tag);
    chk(sel_a_smp_o == 1'b1, {tag, " R1 sel_a"}, int'(sel_a_smp_o), 1);
    chk(sel_b_smp_o == 1'b0, {tag, " R1 sel_b"}, int'(sel_b_smp_o), 0);
    chk(dac_a_code_o == '0, {tag, " R1 code_a"}, int'(dac_a_code_o), 0);
    chk(dac_b_code_o == '0, {tag, " R1 code_b"}, int'(dac_b_code_o), 0);
    chk(result_o == '0 && valid_o == 1'b0, {tag, " R1 result/valid"}, int'(result_o), 0);
    chk(gain_o == 2'd0 && cmp_strobe_o == 1'b0, {tag, " R1 gain/strobe"}, int'(gain_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [NBITS-1:0] old;
    logic             sa;
    vin = VIN_TAB[0];
    repeat (3) @(negedge clk_i);
    reset_checks("start");
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      wait_valid();
      old = VIN_TAB[i];
      // R5 search result
      chk(result_o == old, "R5 result", int'(result_o), int'(old));
      // R3 first conversion on B, then alternating
      chk(sel_a_smp_o == (i % 2 == 0), "R3 converting dac", int'(sel_a_smp_o), int'(i % 2 == 0));
      chk(sel_a_smp_o != sel_b_smp_o, "R2 exclusive roles", int'(sel_b_smp_o), int'(!sel_a_smp_o));
      // R4 nine strobes per period
      chk(strobe_cnt - strobe_prev == NBITS, "R4 strobe count", strobe_cnt - strobe_prev, NBITS);
      strobe_prev = strobe_cnt;
      if (i + 1 < NVEC) vin = VIN_TAB[i+1];
      @(negedge clk_i);
      // R6 one-cycle pulse, result held
      chk(!valid_o && result_o == old, "R6 pulse/hold", int'(valid_o), 0);
      repeat (19) @(negedge clk_i);
      force_hi = 1'b1;
      @(negedge clk_i);
      // R8 comparator ignored in idle cycles
      chk(conv_code == old && result_o == old, "R8 idle hold", int'(conv_code), int'(old));
      // R7 sampler at mid-scale
      chk((sel_a_smp_o ? dac_a_code_o : dac_b_code_o) == MID, "R7 sampler mid",
          int'(sel_a_smp_o ? dac_a_code_o : dac_b_code_o), int'(MID));
      force_hi = 1'b0;
    end

    // R9: change within period, held until swap
    wait_valid();
    repeat (10) @(negedge clk_i);
    gain_sel_i = 2'd2;
    repeat (10) @(negedge clk_i);
    chk(gain_o == 2'd0, "R9 mid-period hold", int'(gain_o), 0);
    repeat (17) @(negedge clk_i);
    sa = sel_a_smp_o;
    chk(gain_o == 2'd0, "R9 hold at cycle 47", int'(gain_o), 0);
    @(negedge clk_i);
    chk(gain_o == 2'd2, "R9 update at swap", int'(gain_o), 2);
    chk(sel_a_smp_o == !sa, "R3 swap after 48", int'(sel_a_smp_o), int'(!sa));
    // R9 with R3: request lands exactly in the swap cycle
    repeat (47) @(negedge clk_i);
    sa = sel_a_smp_o;
    gain_sel_i = 2'd3;
    @(negedge clk_i);
    chk(gain_o == 2'd3 && sel_a_smp_o == !sa, "R9 R3 same-edge", int'(gain_o), 3);
    gain_sel_i = 2'd1;
    @(negedge clk_i);
    chk(gain_o == 2'd3, "R9 ignore after swap", int'(gain_o), 3);

    // R1 reset in the middle of a search
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    reset_checks("midrun");
    vin = 9'h0AA;
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_valid();
    chk(result_o == 9'h0AA, "R5 after reset", int'(result_o), 9'h0AA);
    chk(sel_a_smp_o == 1'b1, "R3 B converts after reset", int'(sel_a_smp_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule